// File: doc/BRIEF.md
# Sixteen-to-One Word Serializer with Gated Loopback Lane

The block turns 16-bit parallel words into a bit stream at sixteen times the word rate. It runs on a fast serial clock supplied from outside, divides that clock by the word width to produce a word clock for the upstream logic, and accepts each word on a separate word-capture clock that the upstream logic returns. That returned clock must rise inside a short, fixed window after the rising edge of the divided clock. Each captured word sits in an input register until a fixed slot late in the word period. At that slot it is handed to a shift register, which sends it most significant bit first.

Alongside the main serial output the block forwards the serial clock and drives a second serial lane for loopback testing. A select input gates this lane: when enabled it follows the main stream bit for bit, and when disabled it is held at 0. A synchronous reset restarts the word timing and keeps the serial output at 0 until the first full word has been handed over.

Top module: `word_serializer`

## Requirements
- R1: The parallel word is sampled only on the rising edge of `pclk_in`. Changes to `pdata` after that edge do not alter the word that is sent.
- R2: After reset is released, count serial clock edges as n = 1, 2, ... After edge n, `pclk_out` is 1 when (n mod 16) < 8 and 0 otherwise, so its period is 16 serial cycles and it rises after edges 1, 16, 32, ... It is 0 while reset is applied.
- R3: Each word is sent most significant bit first: bit 15 goes out first and bit 0 goes out last.
- R4: A word captured by a `pclk_in` rising edge that falls 0 to 3 serial cycles after a `pclk_out` rise is handed to the shift register at the 9th serial edge after that rise (the 8th after the first rise following reset). Its bit 15 is on `sdata` after that edge. For the j-th word (j from 0), this gives bit 15 after edge 16j+9.
- R5: Words leave back to back. Each word takes exactly 16 serial cycles, with no idle bit between consecutive words.
- R6: While `lb_en` is 1, `lb_data` equals `sdata` in every cycle.
- R7: While `lb_en` is 0, `lb_data` is 0.
- R8: `sclk_out` is a forwarded copy of `sclk`, with the same level at all times.
- R9: While reset is applied, `sdata`, `lb_data` and `pclk_out` are 0. After release, `sdata` stays 0 until the first word has been handed over, which means through edge 8.
- R10: A reset applied in the middle of a word discards the word in progress. After release, the timing of R2 and R4 restarts from n = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high, in the serial clock domain |
| pclk_in | input | 1 | Word capture clock returned by the upstream logic |
| pdata | input | 16 | Parallel word, sampled on the rising edge of `pclk_in` |
| lb_en | input | 1 | Loopback lane enable |
| sdata | output | 1 | Serial data, most significant bit first |
| sclk_out | output | 1 | Forwarded serial clock |
| pclk_out | output | 1 | Divided word clock, serial clock divided by 16 |
| lb_data | output | 1 | Loopback serial lane, gated by `lb_en` |

## Verification
The divided clock is due one serial edge after each count step. The first word's bit 15 is due 9 edges after reset release, and bit b of word j is due after edge 16j+9+(15-b). The bench counts serial edges from the release and samples every output on the falling edge that follows, so each sample sees exactly the registers updated by the preceding rising edge. It returns the capture clock at four offsets inside the window and garbles the data bus after each capture. The loopback lane is a combinational gate, so it is compared against `sdata` in the same sample, with the enable changed only after that sample.

// File: rtl/wser_pkg.sv
`timescale 1ns/1ps
package wser_pkg;

    // Default geometry: 16-bit words, handover in the ninth slot of a word period.
    localparam int unsigned WORD_W_DEF  = 16;
    localparam int unsigned LOAD_AT_DEF = 8;

    // Word-timing outputs shared by the timer and the shifter.
    typedef struct packed {
        logic word_strobe;  // hand the captured word to the shift register this cycle
        logic pclk;         // divided word clock level
    } wser_timing_t;

    // Loopback lane mode.
    typedef enum logic {
        LANE_OFF = 1'b0,
        LANE_ON  = 1'b1
    } wser_lane_e;

    // Width of a counter that runs 0 .. n-1.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Divided clock is high for the first half of the word period.
    function automatic logic in_high_half(input int unsigned phase, input int unsigned period);
        return phase < (period / 2);
    endfunction

endpackage

// File: rtl/wser_word_timer.sv
`timescale 1ns/1ps
module wser_word_timer
    import wser_pkg::*;
#(
    parameter int unsigned WORD_W  = WORD_W_DEF,
    parameter int unsigned LOAD_AT = LOAD_AT_DEF
) (
    input  logic         sclk,
    input  logic         rst,
    output wser_timing_t timing
);
    localparam int unsigned CW = cnt_width(WORD_W);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          pclk_q;

    always_comb begin
        if (cnt_q == CW'(WORD_W - 1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // The divided clock is registered from the next count so it leaves a flop.
    always_ff @(posedge sclk) begin
        if (rst) begin
            cnt_q  <= '0;
            pclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pclk_q <= in_high_half(32'(cnt_d), WORD_W);
        end
    end

    // Handover slot sits well after the capture window, well before the next one.
    always_comb begin
        timing.word_strobe = (cnt_q == CW'(LOAD_AT));
        timing.pclk        = pclk_q;
    end

endmodule

// File: rtl/wser_capture.sv
`timescale 1ns/1ps
module wser_capture #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              pclk_in,
    input  logic              rst,
    input  logic [WORD_W-1:0] pdata,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] word_q;

    // Upstream clock domain; reset is sampled on this clock's edges.
    always_ff @(posedge pclk_in) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= pdata;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/wser_shifter.sv
`timescale 1ns/1ps
module wser_shifter
    import wser_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              sclk,
    input  logic              rst,
    input  wser_timing_t      timing,
    input  logic [WORD_W-1:0] word,
    output logic              sdata
);
    typedef struct packed {
        logic              primed;  // a full word has been handed over since reset
        logic [WORD_W-1:0] bits;
    } shift_t;

    shift_t sh_q;
    shift_t sh_d;

    always_comb begin
        sh_d = sh_q;
        if (timing.word_strobe) begin
            sh_d.bits   = word;
            sh_d.primed = 1'b1;
        end else begin
            sh_d.bits = {sh_q.bits[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge sclk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdata = sh_q.primed & sh_q.bits[WORD_W-1];

endmodule

// File: rtl/wser_loop_gate.sv
`timescale 1ns/1ps
module wser_loop_gate
    import wser_pkg::*;
(
    input  logic lb_en,
    input  logic sdata,
    output logic lb_data
);
    wser_lane_e mode;

    always_comb begin
        mode    = lb_en ? LANE_ON : LANE_OFF;
        lb_data = (mode == LANE_ON) ? sdata : 1'b0;
    end

endmodule

// File: rtl/word_serializer.sv
`timescale 1ns/1ps
module word_serializer
    import wser_pkg::*;
#(
    parameter int unsigned WORD_W  = WORD_W_DEF,
    // Handover slot; must lie after the capture window and below WORD_W.
    parameter int unsigned LOAD_AT = LOAD_AT_DEF
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              pclk_in,
    input  logic [WORD_W-1:0] pdata,
    input  logic              lb_en,
    output logic              sdata,
    output logic              sclk_out,
    output logic              pclk_out,
    output logic              lb_data
);
    wser_timing_t      timing;
    logic [WORD_W-1:0] cap_word;

    wser_word_timer #(
        .WORD_W  (WORD_W),
        .LOAD_AT (LOAD_AT)
    ) timer_i (
        .sclk   (sclk),
        .rst    (rst),
        .timing (timing)
    );

    wser_capture #(
        .WORD_W (WORD_W)
    ) capture_i (
        .pclk_in (pclk_in),
        .rst     (rst),
        .pdata   (pdata),
        .word    (cap_word)
    );

    wser_shifter #(
        .WORD_W (WORD_W)
    ) shifter_i (
        .sclk   (sclk),
        .rst    (rst),
        .timing (timing),
        .word   (cap_word),
        .sdata  (sdata)
    );

    wser_loop_gate loop_i (
        .lb_en   (lb_en),
        .sdata   (sdata),
        .lb_data (lb_data)
    );

    assign pclk_out = timing.pclk;
    assign sclk_out = sclk;

endmodule

// File: rtl/word_serializer_chk.sv
`timescale 1ns/1ps
module word_serializer_chk #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned LOAD_AT = 8
) (
    input logic sclk,
    input logic rst,
    input logic pclk_out,
    input logic sdata,
    input logic lb_en,
    input logic lb_data
);
    localparam int unsigned CW   = wser_pkg::cnt_width(WORD_W);
    localparam int unsigned HALF = WORD_W / 2;

    logic [CW-1:0] ph_q;
    logic          ph_ok_q;
    logic [7:0]    since_q;
    logic          rst_seen_q = 1'b0;

    // Independent phase tracker and post-release edge counter.
    always_ff @(posedge sclk) begin
        rst_seen_q <= rst;
        if (rst) begin
            ph_q    <= '0;
            ph_ok_q <= 1'b0;
            since_q <= '0;
        end else begin
            ph_q    <= (ph_q == CW'(WORD_W - 1)) ? '0 : ph_q + 1'b1;
            ph_ok_q <= 1'b1;
            if (since_q != 8'hFF) since_q <= since_q + 1'b1;
        end
    end

    AST_PCLK_PHASE: assert property (@(posedge sclk) disable iff (rst)
        ph_ok_q |-> (pclk_out == (32'(ph_q) < HALF)));                       // R2

    AST_QUIET_BEFORE_LOAD: assert property (@(posedge sclk) disable iff (rst)
        (32'(since_q) <= LOAD_AT) |-> !sdata);                                // R9

    AST_RESET_OUTPUTS: assert property (@(posedge sclk)
        rst_seen_q |-> (!sdata && !pclk_out && !lb_data));                    // R9

    AST_LOOP_FOLLOWS: assert property (@(posedge sclk) disable iff (rst)
        lb_en |-> (lb_data == sdata));                                        // R6

    AST_LOOP_SILENT: assert property (@(posedge sclk) disable iff (rst)
        !lb_en |-> !lb_data);                                                 // R7

endmodule

bind word_serializer word_serializer_chk #(
    .WORD_W  (WORD_W),
    .LOAD_AT (LOAD_AT)
) chk_i (
    .sclk     (sclk),
    .rst      (rst),
    .pclk_out (pclk_out),
    .sdata    (sdata),
    .lb_en    (lb_en),
    .lb_data  (lb_data)
);

// File: tb/word_serializer_tb_top.sv
`timescale 1ns/1ps
module word_serializer_tb_top;
    localparam int W      = 16;
    localparam int FIRST  = 9;                       // edge that shows bit 15 of word 0
    localparam int NWORDS = 36;
    localparam int LIMIT  = FIRST + NWORDS * W - 1;

    logic          sclk    = 1'b0;
    logic          rst     = 1'b1;
    logic          pin_gen = 1'b0;
    logic          pin_rst = 1'b0;
    logic          lb_en   = 1'b0;
    logic [W-1:0]  pdata   = '0;
    logic          pclk_in;
    logic          sdata, sclk_out, pclk_out, lb_data;

    int vec   = 0;
    int bad   = 0;
    int n     = 0;
    int rcnt  = 0;
    int kgen  = 0;
    int phase = 0;
    logic [W-1:0] acc = '0;

    assign pclk_in = pin_gen | pin_rst;

    always #10 sclk = ~sclk;   // 50 MHz serial clock

    word_serializer dut_i (
        .sclk     (sclk),
        .rst      (rst),
        .pclk_in  (pclk_in),
        .pdata    (pdata),
        .lb_en    (lb_en),
        .sdata    (sdata),
        .sclk_out (sclk_out),
        .pclk_out (pclk_out),
        .lb_data  (lb_data)
    );

    function automatic logic [W-1:0] pattern(input int k, input int ph);
        case (k)
            0: return 16'h8000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h0000;
            4: return 16'hA5C3;
            default: return 16'((k * 40503 + ph * 7919) ^ (k << 7) ^ 16'h3C5A);
        endcase
    endfunction

    // Capture-clock offsets after the divided-clock rise, all inside 0..3 cycles.
    function automatic int offset_ns(input int k);
        case (k % 4)
            0: return 1;
            1: return 9;
            2: return 27;
            default: return 45;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, n);
        end
    endtask

    always @(posedge sclk) begin
        n    <= rst ? 0 : n + 1;
        rcnt <= rst ? rcnt + 1 : 0;
    end

    // Upstream model: returns the capture clock inside the window, then garbles the bus (R1).
    always @(posedge pclk_out) begin
        int k;
        k = kgen;
        pdata = pattern(k, phase);
        #(offset_ns(k)) pin_gen = 1'b1;
        #20 pdata = ~pattern(k, phase);
        #100 pin_gen = 1'b0;
        kgen = kgen + 1;
    end

    // R8: forwarded clock is high during the high phase.
    always @(posedge sclk) begin
        if (!rst && n < 24) begin
            #5 check("R8 sclk_out high", 32'(sclk_out), 32'd1);
        end
    end

    always @(negedge sclk) begin
        if (rst) begin
            if (rcnt >= 1) begin
                check("R9 sdata in reset", 32'(sdata), 32'd0);
                check("R9 pclk_out in reset", 32'(pclk_out), 32'd0);
                check("R9 lb_data in reset", 32'(lb_data), 32'd0);
            end
        end else if (n >= 1 && n <= LIMIT) begin
            check("R2 pclk_out phase", 32'(pclk_out), 32'((n % W) < W / 2));
            check("R8 sclk_out low", 32'(sclk_out), 32'd0);
            if (n < FIRST) begin
                check("R9 sdata before first word", 32'(sdata), 32'd0);
            end else begin
                int idx, k, b;
                logic [W-1:0] w;
                idx = n - FIRST;
                k   = idx / W;
                b   = W - 1 - (idx % W);
                w   = pattern(k, phase);
                check("R4 serial bit", 32'(sdata), 32'(w[b]));
                acc = {acc[W-2:0], sdata};
                if (b == 0) begin
                    check("R3 R5 reassembled word", 32'(acc), 32'(w));
                end
            end
            if (lb_en) begin
                check("R6 lb_data follows", 32'(lb_data), 32'(sdata));
            end else begin
                check("R7 lb_data held low", 32'(lb_data), 32'd0);
            end
            lb_en = (((n + 1) / 5) % 3) != 0;   // toggles mid-word
        end
    end

    task automatic run_phase(input int ph);
        phase = ph;
        rst   = 1'b1;
        repeat (12) @(negedge sclk);
        kgen = 0;
        lb_en = 1'b0;
        repeat (2) begin
            #30 pin_rst = 1'b1;
            #30 pin_rst = 1'b0;
        end
        @(posedge sclk);
        #5 rst = 1'b0;
        wait (n == LIMIT);
        @(posedge sclk);
        #5;   // R10: next phase asserts reset in the middle of a word
    endtask

    initial begin
        run_phase(0);
        run_phase(1);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #4000000;
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule